// File: doc/BRIEF.md
# Wavetable memory DMA engine

This block carries a byte stream between the system side and the local wavetable memory. Software programs a control register and a start-address register, then the host side opens a block with a count and a terminal-count flag. Each strobed byte then moves in one cycle. In the download direction (system to local) the byte is written into memory, and its sign bit can be flipped on the way. In the other direction the byte read from memory is handed back to the system side unchanged.

The local address of a block is built from a paragraph-granular start register and a 4-bit sub-paragraph remainder. A 16-bit channel applies a remap that keeps the bank bits and doubles the rest. When a block is accepted, the engine moves the start register and the remainder on by the count. When a block flagged as terminal completes, the request bit is cleared and an interrupt may be raised. Reading the control register acknowledges that interrupt.

Top module: `wt_dma`

## Requirements
- R1: On an 8-bit channel the first byte of a block goes to address `{start, rem}`, that is (start << 4) + rem, where rem is the 4-bit remainder. Later bytes go to consecutive addresses.
- R2: On a 16-bit channel (`wide_chan_i`=1) the first address is `(A & 0xC0000) + 2*(A & 0x1FFF0)`, where A = `{start, rem}`.
- R3: When a block is accepted, start becomes start + (count >> 4) and rem becomes (count + rem) & 0xF. No carry passes from rem into start.
- R4: A block moves count bytes on an 8-bit channel and 2*count bytes on a 16-bit channel, one byte per cycle in which `byte_stb_i` is high. `busy_o` drops in the cycle after the last byte.
- R5: Control bit 1 selects the direction. With 0, each byte from `sys_data_i` is written to memory with `mem_we_o`. With 1, `mem_rdata_i` is presented on `sys_data_o` with `sys_valid_o`, and memory is never written.
- R6: With control bit 7 set and bit 1 clear, bit 7 of every written byte is inverted. Low bytes are exempt when control bit 6 is set: every byte on an 8-bit channel, and the first byte of each pair on a 16-bit channel.
- R7: When a terminal block ends (after its last byte, or at acceptance when the count is 0), control bit 0 is cleared. If control bit 5 is set, the pending flag and `irq_o` are raised.
- R8: A control read returns the stored value with bit 2 forced to `wide_chan_i` and bit 6 set while the interrupt is pending. The read clears the pending flag (`irq_o` falls) and the stored bits 2 and 6.
- R9: A control write with bit 0 set produces a one-cycle `dma_req_o` pulse in the following cycle.
- R10: A start-register write updates only the bytes whose lanes are enabled in `start_be_i`.
- R11: A `xfer_start_i` asserted while `busy_o` is high is ignored. It does not change the running block, the start register or the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_chan_i | input | 1 | Channel is 16-bit |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data |
| ctrl_rd_i | input | 1 | Control register read strobe |
| ctrl_rdata_o | output | 8 | Control read data, valid during the read cycle |
| start_wr_i | input | 1 | Start register write strobe |
| start_be_i | input | 2 | Start register byte-lane enables |
| start_wdata_i | input | 16 | Start register write data |
| dma_req_o | output | 1 | DMA request pulse |
| xfer_start_i | input | 1 | Open a block |
| xfer_count_i | input | 16 | Block count in units |
| xfer_tc_i | input | 1 | Block is terminal |
| byte_stb_i | input | 1 | Move one byte this cycle |
| sys_data_i | input | 8 | Byte from the system side |
| sys_data_o | output | 8 | Byte to the system side |
| sys_valid_o | output | 1 | `sys_data_o` is valid |
| mem_we_o | output | 1 | Local memory write enable |
| mem_addr_o | output | 20 | Local memory address |
| mem_wdata_o | output | 8 | Local memory write data |
| mem_rdata_i | input | 8 | Local memory read data (combinational) |
| busy_o | output | 1 | A block is in progress |
| irq_o | output | 1 | Terminal-count interrupt |

## Verification
Byte moves and control read data are combinational in the cycle of the strobe. The scoreboard monitor therefore compares them at the falling edge of that same cycle. The effects of a transfer become visible one rising edge later: `busy_o`, the terminal-count flags, and the start/remainder advance, which shows up as the first address of the next block. `dma_req_o` is also due one edge after the write. The bench waits one idle cycle after each block before checking status. It checks the pending flag again in the cycle after each acknowledging read.

// File: rtl/wt_dma_pkg.sv
package wt_dma_pkg;
  localparam int CB_REQ   = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_WIDE  = 2;
  localparam int CB_TCIRQ = 5;
  localparam int CB_LOW16 = 6;
  localparam int CB_INV   = 7;

  typedef enum logic {MV_IDLE, MV_RUN} mv_state_e;
endpackage

// File: rtl/wt_dma_addr.sv
module wt_dma_addr #(
  parameter int START_W = 16,
  localparam int ADDR_W = START_W + 4
) (
  input  logic [START_W-1:0] start_i,
  input  logic [3:0]         rem_i,
  input  logic               wide_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [ADDR_W-1:0] off, mid, bank;

  always_comb begin
    off = {start_i, rem_i};
    bank = '0;
    bank[ADDR_W-1:ADDR_W-2] = off[ADDR_W-1:ADDR_W-2];
    mid = '0;
    mid[ADDR_W-4:4] = off[ADDR_W-4:4];
    addr_o = wide_i ? (bank + (mid << 1)) : off;
  end
endmodule

// File: rtl/wt_dma_regs.sv
module wt_dma_regs
  import wt_dma_pkg::*;
#(
  parameter int START_W = 16,
  parameter int CNT_W   = 16,
  localparam int NB     = START_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wide_chan_i,
  input  logic               ctrl_wr_i,
  input  logic [7:0]         ctrl_wdata_i,
  input  logic               ctrl_rd_i,
  output logic [7:0]         ctrl_rdata_o,
  input  logic               start_wr_i,
  input  logic [NB-1:0]      start_be_i,
  input  logic [START_W-1:0] start_wdata_i,
  input  logic               adv_i,
  input  logic [CNT_W-1:0]   adv_count_i,
  input  logic               tc_fire_i,
  output logic [START_W-1:0] start_o,
  output logic [3:0]         rem_o,
  output logic               dir_o,
  output logic               inv_o,
  output logic               low16_o,
  output logic               dma_req_o,
  output logic               irq_o
);
  logic [7:0]         ctrl_q;
  logic [START_W-1:0] start_q;
  logic [3:0]         rem_q;
  logic               pend_q, req_q;
  logic               pend_set;

  assign pend_set = tc_fire_i & ctrl_q[CB_TCIRQ];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q  <= ctrl_wr_i & ctrl_wdata_i[CB_REQ];
      pend_q <= pend_set | (pend_q & ~ctrl_rd_i);
      if (ctrl_wr_i) begin
        ctrl_q <= ctrl_wdata_i;
      end else begin
        if (ctrl_rd_i) begin
          ctrl_q[CB_WIDE]  <= 1'b0;
          ctrl_q[CB_LOW16] <= 1'b0;
        end
        if (tc_fire_i) ctrl_q[CB_REQ] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      rem_q   <= '0;
    end else begin
      if (adv_i) begin
        start_q <= start_q + START_W'(adv_count_i >> 4);
        rem_q   <= adv_count_i[3:0] + rem_q;
      end
      for (int k = 0; k < NB; k++)
        if (start_wr_i && start_be_i[k]) start_q[k*8 +: 8] <= start_wdata_i[k*8 +: 8];
    end
  end

  always_comb begin
    ctrl_rdata_o = '0;
    if (ctrl_rd_i) begin
      ctrl_rdata_o = ctrl_q;
      ctrl_rdata_o[CB_WIDE]  = ctrl_q[CB_WIDE] | wide_chan_i;
      ctrl_rdata_o[CB_LOW16] = ctrl_q[CB_LOW16] | pend_q;
    end
  end

  assign start_o   = start_q;
  assign rem_o     = rem_q;
  assign dir_o     = ctrl_q[CB_DIR];
  assign inv_o     = ctrl_q[CB_INV];
  assign low16_o   = ctrl_q[CB_LOW16];
  assign dma_req_o = req_q;
  assign irq_o     = pend_q;

  assert_tc_clears_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_fire_i && !ctrl_wr_i) |=> !ctrl_q[CB_REQ]);
  assert_irq_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tc_fire_i && ctrl_q[CB_TCIRQ]));
  assert_read_acks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_i && !pend_set) |=> !irq_o);
  assert_req_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> $past(ctrl_wr_i && ctrl_wdata_i[CB_REQ]));
  assert_start_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i && start_be_i == '1) |=> start_q == $past(start_wdata_i));
endmodule

// File: rtl/wt_dma_mover.sv
module wt_dma_mover
  import wt_dma_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_acc_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              tc_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              byte_stb_i,
  input  logic              dir_i,
  input  logic              inv_i,
  input  logic              low16_i,
  input  logic [7:0]        sys_data_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              busy_o,
  output logic              tc_fire_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [7:0]        sys_data_o,
  output logic              sys_valid_o
);
  mv_state_e         state_q;
  logic [CNT_W:0]    left_q, total;
  logic [ADDR_W-1:0] addr_q;
  logic              lo_q, tc_q, wide_q;
  logic              run, step, last, flip;

  assign total = wide_i ? {count_i, 1'b0} : {1'b0, count_i};
  assign run   = (state_q == MV_RUN);
  assign step  = run & byte_stb_i;
  assign last  = step && (left_q == (CNT_W+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MV_IDLE;
      left_q  <= '0;
      addr_q  <= '0;
      lo_q    <= 1'b1;
      tc_q    <= 1'b0;
      wide_q  <= 1'b0;
    end else if (start_acc_i) begin
      addr_q  <= base_i;
      left_q  <= total;
      lo_q    <= 1'b1;
      tc_q    <= tc_i;
      wide_q  <= wide_i;
      state_q <= (total == '0) ? MV_IDLE : MV_RUN;
    end else if (step) begin
      addr_q <= addr_q + 1'b1;
      left_q <= left_q - 1'b1;
      lo_q   <= wide_q ? ~lo_q : 1'b1;
      if (last) state_q <= MV_IDLE;
    end
  end

  // low byte of a 16-bit sample (or any 8-bit byte) skips inversion when low16 set
  assign flip        = inv_i & ~dir_i & ~(low16_i & lo_q);
  assign tc_fire_o   = (start_acc_i & (total == '0) & tc_i) | (last & tc_q);
  assign busy_o      = run;
  assign mem_we_o    = step & ~dir_i;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = sys_data_i ^ {flip, 7'b0};
  assign sys_valid_o = step & dir_i;
  assign sys_data_o  = mem_rdata_i;

  assert_stop_after_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> !busy_o);
  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> mem_addr_o == $past(mem_addr_o) + 1'b1);
  assert_hold_when_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !byte_stb_i) |=> busy_o && $stable(mem_addr_o));
  assert_upload_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_valid_o |-> !mem_we_o);
endmodule

// File: rtl/wt_dma.sv
module wt_dma #(
  parameter int START_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wide_chan_i,
  input  logic                 ctrl_wr_i,
  input  logic [7:0]           ctrl_wdata_i,
  input  logic                 ctrl_rd_i,
  output logic [7:0]           ctrl_rdata_o,
  input  logic                 start_wr_i,
  input  logic [START_W/8-1:0] start_be_i,
  input  logic [START_W-1:0]   start_wdata_i,
  output logic                 dma_req_o,
  input  logic                 xfer_start_i,
  input  logic [CNT_W-1:0]     xfer_count_i,
  input  logic                 xfer_tc_i,
  input  logic                 byte_stb_i,
  input  logic [7:0]           sys_data_i,
  output logic [7:0]           sys_data_o,
  output logic                 sys_valid_o,
  output logic                 mem_we_o,
  output logic [START_W+3:0]   mem_addr_o,
  output logic [7:0]           mem_wdata_o,
  input  logic [7:0]           mem_rdata_i,
  output logic                 busy_o,
  output logic                 irq_o
);
  localparam int ADDR_W = START_W + 4;

  logic [START_W-1:0] start_q;
  logic [3:0]         rem_q;
  logic [ADDR_W-1:0]  base;
  logic               dir, inv, low16, tc_fire, start_acc;

  assign start_acc = xfer_start_i & ~busy_o;

  wt_dma_regs #(.START_W(START_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wide_chan_i,
    .ctrl_wr_i, .ctrl_wdata_i, .ctrl_rd_i, .ctrl_rdata_o,
    .start_wr_i, .start_be_i, .start_wdata_i,
    .adv_i(start_acc), .adv_count_i(xfer_count_i), .tc_fire_i(tc_fire),
    .start_o(start_q), .rem_o(rem_q), .dir_o(dir), .inv_o(inv), .low16_o(low16),
    .dma_req_o, .irq_o
  );

  wt_dma_addr #(.START_W(START_W)) u_addr (
    .start_i(start_q), .rem_i(rem_q), .wide_i(wide_chan_i), .addr_o(base)
  );

  wt_dma_mover #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_mover (
    .clk_i, .rst_ni, .start_acc_i(start_acc), .count_i(xfer_count_i), .tc_i(xfer_tc_i),
    .wide_i(wide_chan_i), .base_i(base), .byte_stb_i, .dir_i(dir), .inv_i(inv),
    .low16_i(low16), .sys_data_i, .mem_rdata_i, .busy_o, .tc_fire_o(tc_fire),
    .mem_we_o, .mem_addr_o, .mem_wdata_o, .sys_data_o, .sys_valid_o
  );
endmodule

// File: tb/tb_wt_dma.sv
module tb_wt_dma;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wide_chan_i = 1'b0, ctrl_wr_i = 1'b0, ctrl_rd_i = 1'b0, start_wr_i = 1'b0;
  logic [7:0]  ctrl_wdata_i = '0, ctrl_rdata_o, sys_data_i = '0, sys_data_o, mem_wdata_o, mem_rdata_i;
  logic [1:0]  start_be_i = '0;
  logic [15:0] start_wdata_i = '0, xfer_count_i = '0;
  logic        xfer_start_i = 1'b0, xfer_tc_i = 1'b0, byte_stb_i = 1'b0;
  logic        dma_req_o, sys_valid_o, mem_we_o, busy_o, irq_o;
  logic [19:0] mem_addr_o;

  int checks = 0, errors = 0;
  logic [28:0] exp_q[$];
  logic [15:0] m_start = '0;
  logic [3:0]  m_rem = '0;
  logic [7:0]  m_ctrl = '0;
  bit          done = 0;

  always #10 clk_i = ~clk_i;
  assign mem_rdata_i = mem_addr_o[7:0] ^ 8'hA5;

  wt_dma dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk_i); #2; endtask

  function automatic logic [19:0] base_addr(input logic [15:0] s, input logic [3:0] r, input logic w);
    logic [19:0] a = {s, r};
    return w ? ((a & 20'hC0000) + 2 * (a & 20'h1FFF0)) : a;
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = v; m_ctrl = v;
    tick; ctrl_wr_i = 1'b0;
  endtask

  task automatic rd_ctrl(input string req, input logic [7:0] exp);
    ctrl_rd_i = 1'b1;
    @(negedge clk_i); chk(req, ctrl_rdata_o, exp);
    tick; ctrl_rd_i = 1'b0;
    m_ctrl[2] = 1'b0; m_ctrl[6] = 1'b0;
  endtask

  task automatic wr_start(input logic [1:0] be, input logic [15:0] v);
    start_wr_i = 1'b1; start_be_i = be; start_wdata_i = v;
    if (be[0]) m_start[7:0] = v[7:0];
    if (be[1]) m_start[15:8] = v[15:8];
    tick; start_wr_i = 1'b0;
  endtask

  // driver: pushes expected byte moves, then drives the stream
  task automatic run_xfer(input int cnt, input bit tc, input bit poke);
    logic [19:0] a = base_addr(m_start, m_rem, wide_chan_i);
    int n = wide_chan_i ? 2 * cnt : cnt;
    m_start = m_start + 16'(cnt >> 4);
    m_rem = 4'(cnt) + m_rem;
    xfer_start_i = 1'b1; xfer_count_i = 16'(cnt); xfer_tc_i = tc;
    tick; xfer_start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'h3C + 8'(i * 17);
      bit lo = !wide_chan_i || (i % 2 == 0);
      bit fl = m_ctrl[7] && !m_ctrl[1] && !(m_ctrl[6] && lo);
      logic [19:0] ai = a + 20'(i);
      if (m_ctrl[1]) exp_q.push_back({1'b1, ai, ai[7:0] ^ 8'hA5});
      else exp_q.push_back({1'b0, ai, d ^ {fl, 7'b0}});
      byte_stb_i = 1'b1; sys_data_i = d;
      if (poke && i == 1) begin xfer_start_i = 1'b1; xfer_count_i = 16'd5; end
      tick; xfer_start_i = 1'b0;
    end
    byte_stb_i = 1'b0;
    tick;
    @(negedge clk_i);
    chk("R4 block finished, busy low", busy_o, 0);
    chk("R4 all expected bytes moved", exp_q.size(), 0);
    exp_q.delete();
    tick;
  endtask

  // monitor: pops and compares each byte move
  initial forever begin
    @(negedge clk_i);
    if (rst_ni && (mem_we_o || sys_valid_o)) begin
      if (mem_we_o && sys_valid_o) chk("R5 one direction only", 1, 0);
      else if (exp_q.size() == 0) chk("R5 unexpected byte move", {mem_we_o, sys_valid_o}, 0);
      else chk("R1 R2 R5 R6 byte move", mem_we_o ? {1'b0, mem_addr_o, mem_wdata_o}
                                                 : {1'b1, mem_addr_o, sys_data_o}, exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst_ni = 1'b1;
    tick;
    @(negedge clk_i);
    chk("R8 reset irq", irq_o, 0);
    chk("R4 reset busy", busy_o, 0);
    chk("R9 reset req", dma_req_o, 0);
    tick;
    rd_ctrl("R8 reset ctrl read", 8'h00);

    wr_start(2'b11, 16'h1234);
    wr_ctrl(8'h01);
    @(negedge clk_i); chk("R9 request pulse", dma_req_o, 1);
    tick; @(negedge clk_i); chk("R9 request pulse ends", dma_req_o, 0);
    tick;
    run_xfer(19, 0, 0);            // R1 base 0x12340
    run_xfer(5, 0, 0);             // R3 base 0x12353
    wr_ctrl(8'h80); run_xfer(3, 0, 0);   // R6 inverted
    wr_ctrl(8'hC0); run_xfer(2, 0, 0);   // R6 low bytes exempt
    wide_chan_i = 1'b1;
    wr_ctrl(8'hC0); wr_start(2'b11, 16'h4567);
    run_xfer(3, 0, 0);             // R2 0x4ACE0, R4 six bytes
    wr_ctrl(8'h80); run_xfer(2, 0, 0);
    wide_chan_i = 1'b0;
    wr_ctrl(8'h82); wr_start(2'b01, 16'h00AB);   // R10 low lane only
    run_xfer(4, 0, 0);             // R5 local to system
    wr_ctrl(8'h00); run_xfer(4, 0, 1);   // R11 poke ignored
    run_xfer(1, 0, 0);
    rd_ctrl("R7 non-terminal keeps state", 8'h00);

    wr_ctrl(8'h21); run_xfer(2, 1, 0);
    @(negedge clk_i); chk("R7 irq raised", irq_o, 1);
    tick;
    rd_ctrl("R7 R8 request cleared, pending reported", 8'h60);
    @(negedge clk_i); chk("R8 read acknowledges irq", irq_o, 0);
    tick;
    rd_ctrl("R8 pending gone", 8'h20);

    wr_ctrl(8'h01); run_xfer(1, 1, 0);
    @(negedge clk_i); chk("R7 no irq without enable", irq_o, 0);
    tick;
    rd_ctrl("R7 request cleared", 8'h00);

    wr_ctrl(8'h21); run_xfer(0, 1, 0);
    @(negedge clk_i); chk("R7 zero count terminal irq", irq_o, 1);
    tick;
    rd_ctrl("R7 zero count read", 8'h60);

    wide_chan_i = 1'b1;
    wr_ctrl(8'hC4);
    rd_ctrl("R8 stored bits read", 8'hC4);
    rd_ctrl("R8 bits 2 and 6 cleared, wide forced", 8'h84);
    wide_chan_i = 1'b0;
    rd_ctrl("R8 narrow channel read", 8'h80);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule